// File: doc/BRIEF.md
# Bridge Drive Trip Latch and Output Gate

This block sits between the pulse-conditioning stage of a single-phase inverter bridge controller and the four switch-drive pins. It decides whether the conditioned drive signals for the two bridge legs reach those pins. An external emergency input is cleaned up on the system clock and then latched. A software-controlled inhibit level and the reset pin also cut the drives. All three blanking sources force every drive low together.

The latched trip survives everything except a reset cycle. It is released on the synchronized rising edge of the reset pin, and only if the emergency input is quiet at that point. While the reset pin is low, the block also asks the waveform counters elsewhere in the chip to sit at zero phase. Two status outputs report the latch state (active low) and whether the drives are live.

Top module: `bridge_trip_gate`

## Requirements
- R1: While `rstPinN` is low, all bits of `driveOut` are 0, `os` is 0 and `cntRst` is 1, starting at once with no clock edge needed. After `rstPinN` rises, `cntRst` stays 1 for one more edge and drops at the second rising clock edge.
- R2: If `setTrip` is driven high just after a clock edge and held, the latch sets on the fourth following edge: two synchronizer stages, then two consecutive high samples. At that edge `tripN` goes to 0 and `driveOut` goes to 0. `cntRst` is not affected by the trip.
- R3: A `setTrip` high pulse that yields fewer than two consecutive synchronized high samples leaves `tripN` at 1 and `driveOut` equal to `driveIn`. This includes a single-cycle pulse and isolated pulses with a low cycle between them.
- R4: Once set, the latch holds after `setTrip` returns low. `tripN` stays 0 and `driveOut` stays 0 for every `driveIn` pattern and every `inhN` level until a reset cycle.
- R5: A reset cycle clears the latch one edge after the synchronized reset release, which is the third rising edge after `rstPinN` rises. The clear happens only if the synchronized `setTrip` is low at that moment. Otherwise `tripN` stays 0.
- R6: While `inhN` is 0, `driveOut` is 0 and `os` is 0, and `tripN` and `cntRst` are unchanged. When `inhN` returns to 1, `driveOut` follows `driveIn` in the same cycle, with no clock edge needed.
- R7: With reset released, no trip and `inhN` at 1, `driveOut` equals `driveIn` bit for bit for every pattern, and `os` is 1. Bit 0 is left top, bit 1 is left bottom, bit 2 is right top and bit 3 is right bottom.
- R8: `os` is 1 exactly when the drives are live. It is 0 during reset, while tripped and while inhibited. `tripN` is 1 whenever the latch is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rstPinN | input | 1 | Asynchronous active-low reset pin |
| setTrip | input | 1 | Emergency trip request, active high, asynchronous |
| inhN | input | 1 | Output inhibit bit, 0 blanks the drives |
| driveIn | input | 4 | Conditioned bridge drives {RB, RT, LB, LT} |
| driveOut | output | 4 | Gated bridge drives to the pins |
| tripN | output | 1 | Trip latch status, 0 when tripped |
| os | output | 1 | 1 when the drives are live |
| cntRst | output | 1 | Hold request for the waveform counters |

## Verification
Suppose the latch was set by a glitch, or never cleared on release. The drives would then stay dead, or come back live while the emergency input is still high. Either fault shows on `tripN` and `driveOut` at the exact edge counted from the stimulus, so the bench samples one edge before and at the expected edge. A wrong synchronizer depth or debounce count moves that edge by a cycle, and that shift is caught. Gating faults show up as a mismatch on one of the sixteen drive patterns swept in each state.

// File: rtl/bridge_trip_pkg.sv
package bridge_trip_pkg;

  // Strobes from control to the datapath.
  typedef struct packed {
    logic tripSet;  // set the trip latch at the next edge
    logic tripClr;  // clear the trip latch at the next edge
    logic runOk;    // synchronized reset released
  } gate_strobe_t;

endpackage

// File: rtl/bridge_trip_rstsync.sv
// Reset synchronizer: asserts asynchronously, releases after STAGES edges.
module bridge_trip_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstPinN,
  output logic rstSyncN
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstPinN) begin
          if (!rstPinN) chain[s] <= 1'b0;
          else          chain[s] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstPinN) begin
          if (!rstPinN) chain[s] <= 1'b0;
          else          chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign rstSyncN = chain[STAGES-1];
endmodule

// File: rtl/bridge_trip_insync.sv
// Plain multi-flop synchronizer for an asynchronous level input.
module bridge_trip_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) chain[s] <= din;
      end else begin : g_next
        always_ff @(posedge clk) chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/bridge_trip_ctrl.sv
// Control: synchronizers, debounce counter, reset release edge detect.
module bridge_trip_ctrl
  import bridge_trip_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TRIP_HITS   = 2
) (
  input  logic         clk,
  input  logic         rstPinN,
  input  logic         setTrip,
  output gate_strobe_t strb,
  output logic         cntRst
);
  localparam int HIT_W = $clog2(TRIP_HITS + 1);
  localparam logic [HIT_W-1:0] HIT_LAST = HIT_W'(TRIP_HITS - 1);

  logic rstSyncN;
  logic rstPrev;
  logic tripS;
  logic [HIT_W-1:0] hitCnt;

  bridge_trip_rstsync #(.STAGES(SYNC_STAGES)) u_rstsync (
    .clk     (clk),
    .rstPinN (rstPinN),
    .rstSyncN(rstSyncN)
  );

  bridge_trip_insync #(.STAGES(SYNC_STAGES)) u_tripsync (
    .clk (clk),
    .din (setTrip),
    .dout(tripS)
  );

  // Consecutive high sample counter; runs through reset so a trip
  // raised while held in reset is still captured.
  always_ff @(posedge clk) begin
    if (!tripS)                 hitCnt <= '0;
    else if (hitCnt != HIT_LAST) hitCnt <= hitCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstPinN) begin
    if (!rstPinN) rstPrev <= 1'b0;
    else          rstPrev <= rstSyncN;
  end

  always_comb begin
    strb.runOk   = rstSyncN;
    strb.tripSet = tripS && (hitCnt == HIT_LAST);
    strb.tripClr = rstSyncN && !rstPrev && !tripS;
  end

  assign cntRst = !rstSyncN;

  // R5: clear and set never requested together
  p_clr_excl_r5: assert property (@(posedge clk) disable iff (!rstPinN)
    strb.tripClr |-> !strb.tripSet);

  // R5: clear is a single pulse per reset release
  p_clr_once_r5: assert property (@(posedge clk) disable iff (!rstPinN)
    strb.tripClr |=> !strb.tripClr);

  // R1: counters held whenever the pin is low
  p_cnt_hold_r1: assert property (@(posedge clk)
    !rstPinN |-> cntRst);
endmodule

// File: rtl/bridge_trip_dp.sv
// Datapath: trip latch state and per-drive output gating.
module bridge_trip_dp
  import bridge_trip_pkg::*;
#(
  parameter int NUM_DRIVES = 4
) (
  input  logic                  clk,
  input  gate_strobe_t          strb,
  input  logic                  inhN,
  input  logic [NUM_DRIVES-1:0] driveIn,
  output logic [NUM_DRIVES-1:0] driveOut,
  output logic                  tripN,
  output logic                  os
);
  logic tripLatch;
  logic liveEn;

  // Set wins; the latch ignores the reset pin and only clears on the
  // release strobe.
  always_ff @(posedge clk) begin
    if (strb.tripSet)      tripLatch <= 1'b1;
    else if (strb.tripClr) tripLatch <= 1'b0;
  end

  assign liveEn = strb.runOk && !tripLatch && inhN;

  generate
    for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drive
      assign driveOut[d] = driveIn[d] & liveEn;
    end
  endgenerate

  assign tripN = !tripLatch;
  assign os    = liveEn;

  // R2: the latch rises only after a set request
  p_set_cause_r2: assert property (@(posedge clk) disable iff (!strb.runOk)
    $rose(tripLatch) |-> $past(strb.tripSet));

  // R4: the latch falls only after a clear request
  p_hold_r4: assert property (@(posedge clk) disable iff (!strb.runOk)
    $fell(tripLatch) |-> $past(strb.tripClr));

  // R2: a set request always lands
  p_set_lands_r2: assert property (@(posedge clk) disable iff (!strb.runOk)
    strb.tripSet |=> tripLatch);
endmodule

// File: rtl/bridge_trip_gate.sv
// Top: thin wrapper tying control strobes to the gating datapath.
module bridge_trip_gate
  import bridge_trip_pkg::*;
#(
  parameter int NUM_DRIVES  = 4,
  parameter int SYNC_STAGES = 2,
  parameter int TRIP_HITS   = 2
) (
  input  logic                  clk,
  input  logic                  rstPinN,
  input  logic                  setTrip,
  input  logic                  inhN,
  input  logic [NUM_DRIVES-1:0] driveIn,
  output logic [NUM_DRIVES-1:0] driveOut,
  output logic                  tripN,
  output logic                  os,
  output logic                  cntRst
);
  gate_strobe_t strb;

  bridge_trip_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .TRIP_HITS  (TRIP_HITS)
  ) u_ctrl (
    .clk    (clk),
    .rstPinN(rstPinN),
    .setTrip(setTrip),
    .strb   (strb),
    .cntRst (cntRst)
  );

  bridge_trip_dp #(.NUM_DRIVES(NUM_DRIVES)) u_dp (
    .clk     (clk),
    .strb    (strb),
    .inhN    (inhN),
    .driveIn (driveIn),
    .driveOut(driveOut),
    .tripN   (tripN),
    .os      (os)
  );

  // R8: tripped means not live
  p_os_trip_r8: assert property (@(posedge clk) disable iff (!rstPinN)
    !tripN |-> !os);

  // R6: not live means all drives quiet
  p_quiet_r6: assert property (@(posedge clk)
    !os |-> (driveOut == '0));
endmodule

// File: tb/bridge_trip_gate_bench.sv
module bridge_trip_gate_bench;
  localparam int SYNC = 2;
  localparam int HITS = 2;
  localparam int LAT  = SYNC + HITS;

  logic       clk = 1'b0;
  logic       rstPinN = 1'b0;
  logic       setTrip = 1'b0;
  logic       inhN = 1'b1;
  logic [3:0] driveIn = 4'hF;
  logic [3:0] driveOut;
  logic       tripN, os, cntRst;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  bridge_trip_gate u_bridge_trip_gate (
    .clk(clk), .rstPinN(rstPinN), .setTrip(setTrip), .inhN(inhN),
    .driveIn(driveIn), .driveOut(driveOut), .tripN(tripN), .os(os),
    .cntRst(cntRst)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [7:0] got, input logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic sweepLive(input string req);
    for (int p = 0; p < 16; p++) begin
      driveIn = 4'(p); #1;
      chk(req, "driveOut live", {4'h0, driveOut}, 8'(p));
      chk(req, "os live", {7'h0, os}, 8'h1);
    end
  endtask

  task automatic sweepDead(input string req);
    for (int p = 0; p < 16; p++) begin
      driveIn = 4'(p); #1;
      chk(req, "driveOut blanked", {4'h0, driveOut}, 8'h0);
      chk(req, "os blanked", {7'h0, os}, 8'h0);
    end
  endtask

  initial begin : watchdog
    #(8 * 200000);
    nFails++; nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    // R1: reset state
    step(3);
    sweepDead("R1");
    chk("R1", "cntRst in reset", {7'h0, cntRst}, 8'h1);
    rstPinN = 1'b1;
    step(1);
    chk("R1", "cntRst one edge after release", {7'h0, cntRst}, 8'h1);
    step(1);
    chk("R1", "cntRst two edges after release", {7'h0, cntRst}, 8'h0);
    step(1);
    chk("R8", "tripN clear after release", {7'h0, tripN}, 8'h1);

    // R7: transparent path
    sweepLive("R7");

    // R6: inhibit
    inhN = 1'b0;
    sweepDead("R6");
    chk("R6", "tripN under inhibit", {7'h0, tripN}, 8'h1);
    chk("R6", "cntRst under inhibit", {7'h0, cntRst}, 8'h0);
    step(2);
    driveIn = 4'hA;
    inhN = 1'b1; #1;
    chk("R6", "resume without edge", {4'h0, driveOut}, 8'hA);

    // R1: asynchronous reset assertion
    rstPinN = 1'b0; #1;
    chk("R1", "driveOut async reset", {4'h0, driveOut}, 8'h0);
    chk("R1", "cntRst async reset", {7'h0, cntRst}, 8'h1);
    step(2);
    rstPinN = 1'b1;
    step(3);
    chk("R7", "live after reset cycle", {4'h0, driveOut}, 8'hA);

    // R3: single-cycle pulse
    driveIn = 4'h5;
    setTrip = 1'b1; step(1); setTrip = 1'b0;
    for (int c = 0; c < 8; c++) begin
      step(1);
      chk("R3", "tripN after short pulse", {7'h0, tripN}, 8'h1);
      chk("R3", "driveOut after short pulse", {4'h0, driveOut}, 8'h5);
    end
    // R3: isolated pulses
    for (int k = 0; k < 3; k++) begin
      setTrip = 1'b1; step(1); setTrip = 1'b0; step(1);
    end
    step(LAT);
    chk("R3", "tripN after spaced pulses", {7'h0, tripN}, 8'h1);

    // R2: trip latency
    driveIn = 4'hF;
    setTrip = 1'b1;
    step(LAT - 1);
    chk("R2", "tripN one edge early", {7'h0, tripN}, 8'h1);
    chk("R2", "driveOut one edge early", {4'h0, driveOut}, 8'hF);
    step(1);
    chk("R2", "tripN at latency", {7'h0, tripN}, 8'h0);
    chk("R2", "driveOut at latency", {4'h0, driveOut}, 8'h0);
    chk("R2", "cntRst while tripped", {7'h0, cntRst}, 8'h0);
    chk("R8", "os while tripped", {7'h0, os}, 8'h0);

    // R4: latch holds
    setTrip = 1'b0;
    step(10);
    chk("R4", "tripN held", {7'h0, tripN}, 8'h0);
    sweepDead("R4");
    inhN = 1'b0; step(2); inhN = 1'b1; step(2);
    chk("R4", "tripN after inhibit toggle", {7'h0, tripN}, 8'h0);
    chk("R4", "driveOut after inhibit toggle", {4'h0, driveOut}, 8'h0);

    // R5: reset with trip still high keeps the latch
    setTrip = 1'b1;
    step(LAT);
    rstPinN = 1'b0;
    step(3);
    chk("R1", "os in reset while tripped", {7'h0, os}, 8'h0);
    rstPinN = 1'b1;
    step(SYNC + 4);
    chk("R5", "tripN kept when trip high", {7'h0, tripN}, 8'h0);
    chk("R5", "driveOut kept low", {4'h0, driveOut}, 8'h0);

    // R5: clean clear timing
    setTrip = 1'b0;
    step(LAT);
    driveIn = 4'h9;
    rstPinN = 1'b0;
    step(2);
    rstPinN = 1'b1;
    step(1);
    chk("R5", "cntRst edge 1", {7'h0, cntRst}, 8'h1);
    step(1);
    chk("R5", "cntRst edge 2", {7'h0, cntRst}, 8'h0);
    chk("R5", "tripN edge 2", {7'h0, tripN}, 8'h0);
    chk("R5", "driveOut edge 2", {4'h0, driveOut}, 8'h0);
    step(1);
    chk("R5", "tripN edge 3", {7'h0, tripN}, 8'h1);
    chk("R5", "driveOut edge 3", {4'h0, driveOut}, 8'h9);
    chk("R8", "os edge 3", {7'h0, os}, 8'h1);

    sweepLive("R7");

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule